// File: doc/BRIEF.md
# Background Configuration Signature Checker

This block walks a configuration memory of `DEPTH` 32-bit words without end, folding one word per enabled cycle into a 32-bit cyclic redundancy signature. When the last word of a pass has been folded in, the finished signature is compared against a reference value held on an input. Any difference raises an error flag that stays set until it is explicitly cleared.

The block runs beside the user logic and never stalls it. The check rate is set by a clock enable, so the time for one pass is `DEPTH` enabled cycles. The error is given twice: once to internal logic, and once through a registered copy meant for a device pin. A mismatch only says that the image differs from the reference. It does not say which bit is wrong. Correction and producing the reference value are left to the surrounding system.

Top module: `crc_bg_checker`

## Requirements
- R1: The signature is a reflected CRC-32 with polynomial 0xEDB88320, start value 0xFFFFFFFF and a final inversion (XOR 0xFFFFFFFF). Each word is fed least significant bit first, which equals the standard CRC-32 of the image laid out as little-endian bytes. Words are taken in ascending address order from 0 to DEPTH-1, and the next pass restarts at 0 with a fresh start value.
- R2: `mem_addr` is driven from a register. The memory must present the word at `mem_addr` on `mem_rdata` in the same cycle, and that word is consumed at the next rising edge where `chk_en` is high.
- R3: While `chk_en` is low, `mem_addr` and the partial signature hold their values and no pass completes. A pass therefore takes exactly DEPTH enabled cycles, however those cycles are spaced.
- R4: `pass_done` is high for exactly one cycle: the cycle after the enabled edge that consumed word DEPTH-1.
- R5: At the edge that raises `pass_done`, `err_core` becomes 1 if the finished signature differs from `ref_crc`. If the two are equal, `err_core` keeps its previous value. A change of `ref_crc` alone is enough to cause a mismatch.
- R6: `err_core` is sticky and returns to 0 only at an edge where `err_clear` is high. If a mismatch is flagged at the same edge as the clear, the flag stays set.
- R7: `err_pin` equals `err_core` delayed by one clock cycle.
- R8: Any image that differs from the reference image in 1, 2 or 3 bits, at any positions, is reported as a mismatch at the end of the pass that reads it.
- R9: Synchronous active-high reset sets `mem_addr` to 0, `pass_done`, `err_core` and `err_pin` to 0, and the signature to its start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Check-rate enable; one word is read per high cycle |
| mem_addr | output | AW = clog2(DEPTH) | Word address into the configuration memory |
| mem_rdata | input | 32 | Word at `mem_addr`, valid in the same cycle |
| ref_crc | input | 32 | Stored reference signature |
| err_clear | input | 1 | Clears the sticky error |
| pass_done | output | 1 | One-cycle strobe at the end of each pass |
| err_core | output | 1 | Sticky mismatch flag for internal logic |
| err_pin | output | 1 | Registered copy of the flag for a device pin |

## Verification
A corrupted address counter or signature register shows up at the ports no later than the end of the current pass. `pass_done` then arrives at the wrong spacing or `err_core` rises against a matching reference. A damaged address step shows within one enabled cycle on `mem_addr`. A faulty error latch is exposed on the first edge after a clear, or after a clean pass that should have left the flag unchanged. Because `err_pin` must trail `err_core` by exactly one cycle, a fault on the pin path is visible on the edge after any change of the flag.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

    localparam int          CRC_W        = 32;
    localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED     = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_XOROUT   = 32'hFFFF_FFFF;

    typedef logic [CRC_W-1:0] crc_t;

    // Per-cycle word beat produced by the address walker
    typedef struct packed {
        logic valid;   // a word is consumed at this edge
        logic last;    // the consumed word is the final one of the pass
    } beat_t;

    // Finished-signature record handed to the verdict stage
    typedef struct packed {
        logic valid;
        crc_t sig;
    } sig_rec_t;

    // Fold 32 data bits into the running reflected CRC, LSB first
    function automatic crc_t crc_fold_word(input crc_t cur, input logic [31:0] data);
        crc_t c;
        c = cur ^ data;
        for (int b = 0; b < 32; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REF) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_addr_seq.sv
module crc_addr_seq
    import crc_chk_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [AW-1:0] addr,
    output beat_t         beat
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;
    logic          at_last;

    assign at_last = (addr_q == LAST_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (en) begin
            addr_q <= at_last ? '0 : addr_q + AW'(1);
        end
    end

    always_comb begin
        beat.valid = en;
        beat.last  = en & at_last;
    end

    assign addr = addr_q;

endmodule

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
    import crc_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  beat_t       beat,
    input  logic [31:0] word,
    output sig_rec_t    fin
);
    crc_t acc_q;
    crc_t acc_next;

    assign acc_next = crc_fold_word(acc_q, word);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= CRC_SEED;
        end else if (beat.valid) begin
            acc_q <= beat.last ? CRC_SEED : acc_next;
        end
    end

    always_comb begin
        fin.valid = beat.last;
        fin.sig   = acc_next ^ CRC_XOROUT;
    end

endmodule

// File: rtl/crc_verdict.sv
module crc_verdict
    import crc_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sig_rec_t fin,
    input  crc_t     ref_sig,
    input  logic     clr,
    output logic     done,
    output logic     err_flag,
    output logic     err_pad
);
    logic mismatch;
    logic done_q;
    logic err_q;
    logic pad_q;

    assign mismatch = fin.valid & (fin.sig != ref_sig);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            pad_q  <= 1'b0;
        end else begin
            done_q <= fin.valid;
            if (mismatch) begin
                err_q <= 1'b1;
            end else if (clr) begin
                err_q <= 1'b0;
            end
            pad_q <= err_q;
        end
    end

    assign done     = done_q;
    assign err_flag = err_q;
    assign err_pad  = pad_q;

endmodule

// File: rtl/crc_bg_checker.sv
module crc_bg_checker
    import crc_chk_pkg::*;
#(
    parameter  int DEPTH = 1024,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chk_en,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    input  logic [31:0]   ref_crc,
    input  logic          err_clear,
    output logic          pass_done,
    output logic          err_core,
    output logic          err_pin
);
    beat_t    beat;
    sig_rec_t fin;

    crc_addr_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .en   (chk_en),
        .addr (mem_addr),
        .beat (beat)
    );

    crc_fold_unit u_fold (
        .clk  (clk),
        .rst  (rst),
        .beat (beat),
        .word (mem_rdata),
        .fin  (fin)
    );

    crc_verdict u_verdict (
        .clk      (clk),
        .rst      (rst),
        .fin      (fin),
        .ref_sig  (ref_crc),
        .clr      (err_clear),
        .done     (pass_done),
        .err_flag (err_core),
        .err_pad  (err_pin)
    );

endmodule

// File: rtl/crc_bg_checker_sva.sv
module crc_bg_checker_sva #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          chk_en,
    input logic [AW-1:0] mem_addr,
    input logic          err_clear,
    input logic          pass_done,
    input logic          err_core,
    input logic          err_pin
);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> $stable(mem_addr));

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
        (chk_en && mem_addr != LAST_A) |=> mem_addr == $past(mem_addr) + AW'(1));

    assert_addr_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (chk_en && mem_addr == LAST_A) |=> mem_addr == '0);

    assert_done_cause_R4: assert property (@(posedge clk) disable iff (rst)
        (chk_en && mem_addr == LAST_A) |=> pass_done);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        pass_done |=> !pass_done);

    assert_err_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_core) |-> pass_done);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (err_core && !err_clear) |=> err_core);

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (err_clear && !(chk_en && mem_addr == LAST_A)) |=> !err_core);

    assert_pin_lag_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> err_pin == $past(err_core));

endmodule

bind crc_bg_checker crc_bg_checker_sva #(.DEPTH(DEPTH), .AW(AW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (chk_en),
    .mem_addr  (mem_addr),
    .err_clear (err_clear),
    .pass_done (pass_done),
    .err_core  (err_core),
    .err_pin   (err_pin)
);

// File: tb/tb_crc_bg_checker.sv
`timescale 1ns/1ps
module tb_crc_bg_checker;
    localparam int D  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chk_en = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic [31:0]   ref_crc = '0;
    logic          err_clear = 1'b0;
    logic          pass_done;
    logic          err_core;
    logic          err_pin;

    logic [31:0] mem [D];
    logic [31:0] golden [D];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign mem_rdata = mem[mem_addr];

    crc_bg_checker #(.DEPTH(D)) dut (
        .clk(clk), .rst(rst), .chk_en(chk_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .ref_crc(ref_crc), .err_clear(err_clear),
        .pass_done(pass_done), .err_core(err_core), .err_pin(err_pin)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Standard byte-wise CRC-32 over the image as little-endian bytes
    function automatic logic [31:0] model_crc();
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int w = 0; w < D; w++) begin
            for (int k = 0; k < 4; k++) begin
                c = c ^ {24'h0, mem[w][8*k +: 8]};
                for (int b = 0; b < 8; b++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    task automatic restore();
        for (int w = 0; w < D; w++) mem[w] = golden[w];
    endtask

    // Starts at a negedge with chk_en low and mem_addr 0
    task automatic run_pass(input logic exp_err, input string req);
        chk_en = 1'b1;
        repeat (D) @(posedge clk);
        @(negedge clk);
        chk_en = 1'b0;
        check(pass_done === 1'b1, "R4", {31'h0, pass_done}, 32'h1);
        check(err_core === exp_err, req, {31'h0, err_core}, {31'h0, exp_err});
        check(mem_addr === '0, "R1", {28'h0, mem_addr}, 32'h0);
        @(negedge clk);
        check(pass_done === 1'b0, "R4", {31'h0, pass_done}, 32'h0);
        check(err_pin === exp_err, "R7", {31'h0, err_pin}, {31'h0, exp_err});
    endtask

    task automatic do_clear();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check(err_core === 1'b0, "R6", {31'h0, err_core}, 32'h0);
        @(negedge clk);
        check(err_pin === 1'b0, "R7", {31'h0, err_pin}, 32'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_addr === '0, "R9", {28'h0, mem_addr}, 32'h0);
        check(pass_done === 1'b0, "R9", {31'h0, pass_done}, 32'h0);
        check(err_core === 1'b0, "R9", {31'h0, err_core}, 32'h0);
        check(err_pin === 1'b0, "R9", {31'h0, err_pin}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_clean();
        ref_crc = model_crc();
        run_pass(1'b0, "R1");
        run_pass(1'b0, "R5");
    endtask

    task automatic t_single_flip();
        mem[5][17] = ~mem[5][17];
        run_pass(1'b1, "R8");
        restore();
        run_pass(1'b1, "R6");   // still set after a clean pass
        do_clear();
        run_pass(1'b0, "R6");
    endtask

    task automatic t_multi_flip();
        mem[0][0] = ~mem[0][0];
        mem[D-1][31] = ~mem[D-1][31];
        run_pass(1'b1, "R8");
        restore();
        do_clear();
        mem[2][3] = ~mem[2][3];
        mem[2][4] = ~mem[2][4];
        mem[9][30] = ~mem[9][30];
        run_pass(1'b1, "R8");
        restore();
        do_clear();
        run_pass(1'b0, "R8");
    endtask

    task automatic t_ref_change();
        ref_crc = ref_crc ^ 32'h8000_0000;
        run_pass(1'b1, "R5");
        ref_crc = model_crc();
        do_clear();
    endtask

    task automatic t_pacing();
        int bad_addr = 0;
        int early = 0;
        for (int i = 0; i < 2*D; i++) begin
            chk_en = i[0];
            @(posedge clk);
            @(negedge clk);
            if (i < 2*D-1) begin
                if (pass_done !== 1'b0) early++;
                if (mem_addr !== AW'(((i+1)/2) % D)) bad_addr++;
            end
        end
        chk_en = 1'b0;
        check(bad_addr == 0, "R3", bad_addr, 0);
        check(early == 0, "R3", early, 0);
        check(pass_done === 1'b1, "R3", {31'h0, pass_done}, 32'h1);
        check(mem_addr === '0, "R2", {28'h0, mem_addr}, 32'h0);
        check(err_core === 1'b0, "R2", {31'h0, err_core}, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_clear_collide();
        // mismatch flagged at the same edge the clear is applied
        ref_crc = ~ref_crc;
        chk_en = 1'b1;
        repeat (D-1) @(posedge clk);
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        chk_en = 1'b0;
        check(err_core === 1'b1, "R6", {31'h0, err_core}, 32'h1);
        ref_crc = model_crc();
        @(negedge clk);
        do_clear();
    endtask

    initial begin
        for (int w = 0; w < D; w++) begin
            golden[w] = 32'h1234_5678 * (w + 1) ^ (32'hA5A5_0000 >> w);
            mem[w] = golden[w];
        end
        @(negedge clk);
        t_reset();
        t_clean();
        t_single_flip();
        t_multi_flip();
        t_ref_change();
        t_pacing();
        t_clear_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule